// File: doc/BRIEF.md
# Pen-Interrupt Arming Controller

This block decides when the pen-detect path of a resistive touch controller is armed. It drives three outputs: the open-drain enable of the active-low pen interrupt line, the switch that connects the X+ node to the detector, and the driver that holds Y− at ground. When the block is armed and idle, Y− is grounded and X+ is connected to the detector. A touch pulls X+ low, and that in turn pulls the interrupt line low. The touch is modelled as the digital level `touch_low`.

The serial-bus front end feeds the block three kinds of input. The first is bus events: an acknowledged address byte with a write direction, and the Stop or repeated Start that closes a transfer. The second is the decoded command fields: channel code, power-down bit and resolution. The third is a conversion-done strobe. Any write address disarms detection. The last command of the transfer decides what follows the closing bus event:
- a panel-driver-only command forces the interrupt line low;
- a command with the power-down bit set leaves detection off;
- any other command re-arms detection once the conversion time has run out. A parameterised count of system clocks sets that time, with separate counts for 12-bit and 8-bit mode. An earlier conversion-done strobe also re-arms detection.

Top module: `pen_irq_ctrl`

## Requirements
- R1: After reset the block is armed: `ym_gnd`=1, `xp_det_sw`=1, and `pen_pull` follows `touch_low`. Reset is asynchronous and active-low, and its release is synchronised over two clocks.
- R2: While armed, `pen_pull` equals `touch_low` in the same cycle.
- R3: The cycle after `addr_wr_ack` is sampled high, all three outputs are 0, whatever the state and whatever `touch_low` is.
- R4: Channel code bits [3:2] select the command class: 2'b11 is position measurement, 2'b10 is panel-driver only, and any other value is a non-panel measurement. In every state other than armed, `xp_det_sw`=0 and `ym_gnd`=0.
- R5: If the last command of a transfer is driver-only, then from the cycle after `bus_end` onward `pen_pull`=1, `xp_det_sw`=0 and `ym_gnd`=0. This holds whatever `cmd_pd0` and `touch_low` are, until the next `addr_wr_ack`.
- R6: If the last command of a transfer is a measurement with `cmd_pd0`=1, then after `bus_end` all outputs stay 0, whatever `touch_low` is. This lasts until a later transfer whose last command has `cmd_pd0`=0 re-arms the block.
- R7: If the last command is a measurement with `cmd_pd0`=0, the block re-arms exactly CONV_CYC_12 cycles after the cycle in which `bus_end` is sampled when `cmd_res8`=0, and exactly CONV_CYC_8 cycles after it when `cmd_res8`=1.
- R8: If `conv_done` is high during the re-arm wait, the block is armed in the next cycle.
- R9: `cmd_valid` and `bus_end` are ignored when no write address has been acknowledged since the last closing bus event.
- R10: When a transfer holds several commands, only the last one decides the outcome.
- R11: A transfer closed with no command reuses the fields of the last command stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_wr_ack | input | 1 | Pulse: write address byte acknowledged |
| cmd_valid | input | 1 | Pulse: command byte decoded |
| cmd_chan | input | CHAN_W | Channel code of the command |
| cmd_pd0 | input | 1 | Power-down bit of the command |
| cmd_res8 | input | 1 | 1 selects 8-bit mode, 0 selects 12-bit mode |
| bus_end | input | 1 | Pulse: Stop or repeated Start |
| conv_done | input | 1 | Pulse: conversion finished |
| touch_low | input | 1 | 1 when a touch pulls X+ low |
| pen_pull | output | 1 | 1 pulls the interrupt line low |
| xp_det_sw | output | 1 | 1 connects X+ to the detector |
| ym_gnd | output | 1 | 1 drives Y− to ground |

## Verification
The hardest situation to reach is the re-arm boundary. Arming has to be caught in exactly the cycle the count ends, in each resolution mode, and it must not be caught one cycle early. The stimulus runs full transfers (address acknowledge, command, then closing event) and checks every cycle of the wait, using short terminal counts so that the 12-bit and 8-bit cases give different expected cycles. Three further situations are reached through real transfers: stray bus events outside a transfer, several commands in one transfer, and a transfer closed with no command.

// File: rtl/pen_irq_pkg.sv
package pen_irq_pkg;
  parameter int CHAN_W = 4;

  typedef enum logic [2:0] {
    ST_ARMED,
    ST_BUSY,
    ST_WAIT,
    ST_OFF,
    ST_DRIVE
  } pen_state_e;

  typedef enum logic [1:0] {
    CL_OTHER,
    CL_POSITION,
    CL_DRIVE
  } cmd_class_e;

  typedef struct packed {
    cmd_class_e cls;
    logic       pd0;
    logic       res8;
  } cmd_s;

  function automatic cmd_class_e classify(input logic [CHAN_W-1:0] chan);
    case (chan[CHAN_W-1 -: 2])
      2'b11:   return CL_POSITION;
      2'b10:   return CL_DRIVE;
      default: return CL_OTHER;
    endcase
  endfunction
endpackage

// File: rtl/pen_cmd_latch.sv
module pen_cmd_latch
  import pen_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture_en,
  input  logic [CHAN_W-1:0] chan,
  input  logic              pd0,
  input  logic              res8,
  output cmd_s              cmd_q
);
  cmd_s cmd_d;

  always_comb begin
    cmd_d = cmd_q;
    if (capture_en) begin
      cmd_d.cls  = classify(chan);
      cmd_d.pd0  = pd0;
      cmd_d.res8 = res8;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q.cls  <= CL_OTHER;
      cmd_q.pd0  <= 1'b0;
      cmd_q.res8 <= 1'b0;
    end else begin
      cmd_q <= cmd_d;
    end
  end

  // A command seen outside a transfer must leave the stored fields alone
  assert_cmd_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !capture_en |=> $stable(cmd_q));
endmodule

// File: rtl/pen_rearm_timer.sv
module pen_rearm_timer #(
  parameter int CONV_CYC_12 = 2500,
  parameter int CONV_CYC_8  = 1750
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic run,
  input  logic res8,
  output logic expired
);
  localparam int MAXC  = (CONV_CYC_12 > CONV_CYC_8) ? CONV_CYC_12 : CONV_CYC_8;
  localparam int CNT_W = (MAXC > 1) ? $clog2(MAXC) : 1;
  localparam logic [CNT_W-1:0] TERM12 = CNT_W'(CONV_CYC_12 - 1);
  localparam logic [CNT_W-1:0] TERM8  = CNT_W'(CONV_CYC_8 - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d, term;

  assign term    = res8 ? TERM8 : TERM12;
  assign expired = run && (cnt_q == term);

  always_comb begin
    cnt_d = cnt_q;
    if (start)
      cnt_d = '0;
    else if (run && !expired)
      cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // The count never passes the terminal value of the selected mode
  assert_count_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> cnt_q <= term);
endmodule

// File: rtl/pen_arm_fsm.sv
module pen_arm_fsm
  import pen_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       addr_wr_ack,
  input  logic       bus_end,
  input  logic       conv_done,
  input  logic       timer_expired,
  input  cmd_s       cmd_q,
  output pen_state_e state_q
);
  pen_state_e state_d;

  always_comb begin
    state_d = state_q;
    if (addr_wr_ack) begin
      state_d = ST_BUSY;
    end else begin
      case (state_q)
        ST_BUSY: if (bus_end) begin
          if (cmd_q.cls == CL_DRIVE) state_d = ST_DRIVE;
          else if (cmd_q.pd0)        state_d = ST_OFF;
          else                       state_d = ST_WAIT;
        end
        ST_WAIT: if (timer_expired || conv_done) state_d = ST_ARMED;
        default: state_d = state_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_ARMED;
    else        state_q <= state_d;
  end

  assert_ack_disarms_R3: assert property (@(posedge clk) disable iff (!rst_n)
    addr_wr_ack |=> state_q == ST_BUSY);
  assert_drive_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DRIVE && !addr_wr_ack) |=> state_q == ST_DRIVE);
  assert_off_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_OFF && !addr_wr_ack) |=> state_q == ST_OFF);
  assert_rearm_from_wait_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(state_q == ST_ARMED) |-> $past(state_q) == ST_WAIT);
endmodule

// File: rtl/pen_irq_ctrl.sv
module pen_irq_ctrl
  import pen_irq_pkg::*;
#(
  parameter int CONV_CYC_12 = 2500,
  parameter int CONV_CYC_8  = 1750
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_wr_ack,
  input  logic              cmd_valid,
  input  logic [CHAN_W-1:0] cmd_chan,
  input  logic              cmd_pd0,
  input  logic              cmd_res8,
  input  logic              bus_end,
  input  logic              conv_done,
  input  logic              touch_low,
  output logic              pen_pull,
  output logic              xp_det_sw,
  output logic              ym_gnd
);
  logic [1:0] rst_sync_q;
  logic       rst_n_s;
  pen_state_e state_q;
  cmd_s       cmd_q;
  logic       in_busy, tmr_start, tmr_run, tmr_expired;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  assign in_busy   = (state_q == ST_BUSY);
  assign tmr_start = in_busy && bus_end && !addr_wr_ack;
  assign tmr_run   = (state_q == ST_WAIT);

  pen_cmd_latch u_cmd (
    .clk(clk), .rst_n(rst_n_s),
    .capture_en(in_busy && cmd_valid && !addr_wr_ack),
    .chan(cmd_chan), .pd0(cmd_pd0), .res8(cmd_res8),
    .cmd_q(cmd_q)
  );

  pen_rearm_timer #(.CONV_CYC_12(CONV_CYC_12), .CONV_CYC_8(CONV_CYC_8)) u_tmr (
    .clk(clk), .rst_n(rst_n_s),
    .start(tmr_start), .run(tmr_run), .res8(cmd_q.res8),
    .expired(tmr_expired)
  );

  pen_arm_fsm u_fsm (
    .clk(clk), .rst_n(rst_n_s),
    .addr_wr_ack(addr_wr_ack), .bus_end(bus_end), .conv_done(conv_done),
    .timer_expired(tmr_expired), .cmd_q(cmd_q), .state_q(state_q)
  );

  always_comb begin
    pen_pull  = 1'b0;
    xp_det_sw = 1'b0;
    ym_gnd    = 1'b0;
    case (state_q)
      ST_ARMED: begin
        pen_pull  = touch_low;
        xp_det_sw = 1'b1;
        ym_gnd    = 1'b1;
      end
      ST_DRIVE: pen_pull = 1'b1;
      default: ;
    endcase
  end

  assert_det_off_when_unarmed_R4: assert property (@(posedge clk) disable iff (!rst_n_s)
    (state_q != ST_ARMED) |-> (!xp_det_sw && !ym_gnd));
  assert_armed_follows_touch_R2: assert property (@(posedge clk) disable iff (!rst_n_s)
    xp_det_sw |-> (pen_pull == touch_low));
endmodule

// File: tb/pen_irq_ctrl_tb.sv
module pen_irq_ctrl_tb_top;
  localparam int C12 = 20;
  localparam int C8  = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ack = 0, cv = 0, pd0 = 0, r8 = 0, bend = 0, cdone = 0, touch = 0;
  logic [3:0] chan = 4'h0;
  logic pen_pull, xp_det_sw, ym_gnd;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    logic  pull;
    logic  xp;
    logic  ym;
    string req;
  } exp_t;
  exp_t q[$];

  always #2 clk = ~clk;

  pen_irq_ctrl #(.CONV_CYC_12(C12), .CONV_CYC_8(C8)) dut_i (
    .clk(clk), .rst_n(rst_n), .addr_wr_ack(ack), .cmd_valid(cv),
    .cmd_chan(chan), .cmd_pd0(pd0), .cmd_res8(r8), .bus_end(bend),
    .conv_done(cdone), .touch_low(touch),
    .pen_pull(pen_pull), .xp_det_sw(xp_det_sw), .ym_gnd(ym_gnd)
  );

  // Monitor: compare at the falling edge
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      if (e.req != "") begin
        checks++;
        if ({pen_pull, xp_det_sw, ym_gnd} !== {e.pull, e.xp, e.ym}) begin
          errors++;
          $display("FAIL %s: got pull/xp/ym=%b%b%b expected %b%b%b",
                   e.req, pen_pull, xp_det_sw, ym_gnd, e.pull, e.xp, e.ym);
        end
      end
    end
  end

  // One cycle of stimulus plus the outputs expected in that same cycle
  task automatic tick(input logic a, input logic c, input logic [3:0] ch,
                      input logic p, input logic r, input logic b,
                      input logic d, input logic t,
                      input logic ep, input logic ex, input logic ey,
                      input string req);
    exp_t e;
    @(posedge clk); #1;
    ack = a; cv = c; chan = ch; pd0 = p; r8 = r; bend = b; cdone = d; touch = t;
    e.pull = ep; e.xp = ex; e.ym = ey; e.req = req;
    q.push_back(e);
  endtask

  task automatic idle_n(input int n, input logic t, input logic ep,
                        input logic ex, input logic ey, input string req);
    for (int i = 0; i < n; i++) tick(0,0,4'h0,0,0,0,0,t, ep,ex,ey, req);
  endtask

  // Acknowledge, one command, closing event; outputs seen while armed before
  task automatic xfer(input logic [3:0] ch, input logic p, input logic r,
                      input logic t, input logic ep0, input logic ex0,
                      input logic ey0, input string req);
    tick(1,0,4'h0,0,0,0,0,t, ep0,ex0,ey0, req);
    tick(0,1,ch,p,r,0,0,t, 0,0,0, "R3");
    tick(0,0,4'h0,0,0,1,0,t, 0,0,0, "R3");
  endtask

  initial begin : driver
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    // R1 / R2: armed after reset
    tick(0,0,0,0,0,0,0,0, 0,1,1, "R1");
    tick(0,0,0,0,0,0,0,1, 1,1,1, "R2");
    tick(0,0,0,0,0,0,0,0, 0,1,1, "R2");
    // R7: position measurement, 12-bit
    xfer(4'hC, 0, 0, 1, 1,1,1, "R2");
    idle_n(C12, 1, 0,0,0, "R7 12-bit wait");
    tick(0,0,0,0,0,0,0,1, 1,1,1, "R7 12-bit rearm");
    // R4/R7: non-panel measurement, 8-bit
    xfer(4'h2, 0, 1, 0, 0,1,1, "R2");
    idle_n(C8, 1, 0,0,0, "R7 8-bit wait");
    tick(0,0,0,0,0,0,0,1, 1,1,1, "R7 8-bit rearm");
    // R6: power-down bit set, plus stray events (R9)
    xfer(4'h1, 1, 0, 1, 1,1,1, "R2");
    idle_n(4, 1, 0,0,0, "R6");
    tick(0,1,4'hC,0,1,0,0,1, 0,0,0, "R6");
    tick(0,0,0,0,0,1,0,1, 0,0,0, "R9");
    idle_n(C12+2, 1, 0,0,0, "R9 stray ignored");
    // R6 release: new transfer with pd0=0, 8-bit
    xfer(4'hC, 0, 1, 0, 0,0,0, "R6");
    idle_n(C8, 0, 0,0,0, "R7");
    tick(0,0,0,0,0,0,0,1, 1,1,1, "R6 rearmed");
    // R5: driver-only command forces low whatever pd0
    xfer(4'h8, 1, 0, 0, 0,1,1, "R2");
    idle_n(3, 0, 1,0,0, "R5");
    idle_n(3, 1, 1,0,0, "R5");
    tick(0,0,0,0,0,1,0,0, 1,0,0, "R9");
    idle_n(C12+2, 0, 1,0,0, "R5 held");
    // R3 from drive state, then R8 early conversion done
    xfer(4'hD, 0, 0, 1, 1,0,0, "R5");
    idle_n(3, 1, 0,0,0, "R8 wait");
    tick(0,0,0,0,0,0,1,1, 0,0,0, "R8");
    tick(0,0,0,0,0,0,0,1, 1,1,1, "R8 early rearm");
    // R10: two commands, last (pd0=0, 8-bit) wins
    tick(1,0,0,0,0,0,0,0, 0,1,1, "R2");
    tick(0,1,4'h4,1,0,0,0,0, 0,0,0, "R3");
    tick(0,1,4'h4,0,1,0,0,0, 0,0,0, "R10");
    tick(0,0,0,0,0,1,0,0, 0,0,0, "R10");
    idle_n(C8, 1, 0,0,0, "R10 wait");
    tick(0,0,0,0,0,0,0,1, 1,1,1, "R10 rearm");
    // R11: transfer with no command reuses stored 8-bit pd0=0
    tick(1,0,0,0,0,0,0,1, 1,1,1, "R2");
    tick(0,0,0,0,0,1,0,1, 0,0,0, "R11");
    idle_n(C8, 1, 0,0,0, "R11 wait");
    tick(0,0,0,0,0,0,0,1, 1,1,1, "R11 rearm");
    idle_n(2, 0, 0,1,1, "R1");
    done = 1;
  end

  initial begin : finisher
    int cyc;
    cyc = 0;
    while (!(done && q.size() == 0) && cyc < 5000) begin
      @(posedge clk);
      cyc++;
    end
    if (cyc >= 5000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
    end
    @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule